// File: doc/BRIEF.md
# ADC Capture Delay Training Controller

This block sets the input capture delays of a parallel ADC data interface so that received samples are taken inside the valid data eye. It keeps one 5-bit tap counter for the capture clock path and one for each of two data ports. Each tap is one step of about 75 ps in an external programmable delay element. The block drives that element with the current tap values and with a one-cycle strobe for every single-tap step.

Software works through a small write-only register port. It can step any of the three taps by hand, return all taps to zero, choose the pattern the ADC is sending, and start an automatic sweep. The sweep moves the clock tap upward from a programmable start value to the top tap. At each tap it checks a block of consecutive samples against the expected ramp or constant pattern. It then parks the clock tap in the centre of the longest error-free stretch of taps. The tap values are outputs, so the result of training can always be read back.

Top module: `adc_eye_trainer`

## Requirements
- R1: After reset, the three tap outputs are 0, no step strobe is high, and busy, done and fail are low. Every tap value stays within 0 to 31.
- R2: Writing 0x13 to register address 0 while idle sets all three taps to 0 and clears done and fail. Any other value written to address 0, except the start code 0x40, changes nothing.
- R3: Writing address 2 while idle steps taps by one. Bit 2 steps the clock tap, bit 0 steps data port A and bit 1 steps data port B, and several bits may be set in one write. The new value and a one-cycle step strobe for each tap that moved appear in the cycle after the write.
- R4: A step request on a tap that is already 31 leaves it at 31 and raises no strobe.
- R5: While training is busy, every register write is ignored, including steps, the 0x13 reset code and configuration writes. The data taps do not change during training.
- R6: Address 1 bits 4:0 hold the sweep start tap. Address 3 bit 0 selects the pattern: 0 for a ramp, 1 for the constant on the patConst input. Writing 0x40 to address 0 loads the clock tap with the start tap in the next cycle and raises busy.
- R7: At each tap from the start tap to 31, the sweep waits a settle time, takes one valid sample as a seed, and then checks 256 further valid samples. In ramp mode each sample must equal the previous one plus 1, modulo 2^14. In constant mode each sample must equal patConst. Any mismatched bit fails the tap.
- R8: When the sweep ends, the clock tap is loaded with first + (length-1)/2 of the longest run of consecutive passing taps. If two runs are equally long, the lower run is used.
- R9: If no tap passes, fail is set and the clock tap returns to the start tap.
- R10: Done rises exactly one cycle after the final clock tap is loaded, and busy falls in that same cycle. Done stays high until the next start command, the 0x13 code or reset, and it is never high while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 8 | Register write data |
| sampleValid | input | 1 | ADC sample valid |
| sampleIn | input | 14 | ADC sample word |
| patConst | input | 14 | Expected value in constant-pattern mode |
| clkTap | output | 5 | Capture clock delay tap |
| dataTapA | output | 5 | Data port A delay tap |
| dataTapB | output | 5 | Data port B delay tap |
| clkStepStb | output | 1 | Clock tap stepped by one |
| dataStepStbA | output | 1 | Port A tap stepped by one |
| dataStepStbB | output | 1 | Port B tap stepped by one |
| trainBusy | output | 1 | Automatic training in progress |
| trainDone | output | 1 | Training finished |
| trainFail | output | 1 | Training found no passing tap |

## Verification
The hardest outcomes to reach are the window choices: a run clipped by the start tap, two runs where the longer one lies higher, two equally long runs, and a sweep in which no tap passes. None of these can be set from the register port. The bench models the delay element as a 32-bit mask of good clock taps. Whenever the current clock tap is outside the mask, it flips one bit of every 50th sample, so every bad tap is certain to see errors inside its 256-sample block. Directed masks reach each corner case, and seeded random masks and random valid gaps cover the rest, with the expected centre computed by a bench function.

// File: rtl/adc_trn_pkg.sv
package adc_trn_pkg;
  localparam int REG_AW = 2;
  localparam int REG_DW = 8;

  localparam logic [REG_AW-1:0] ADR_CMD   = 2'd0;
  localparam logic [REG_AW-1:0] ADR_START = 2'd1;
  localparam logic [REG_AW-1:0] ADR_STEP  = 2'd2;
  localparam logic [REG_AW-1:0] ADR_PAT   = 2'd3;

  localparam logic [REG_DW-1:0] CMD_TAP_RESET = 8'h13;
  localparam logic [REG_DW-1:0] CMD_TRAIN     = 8'h40;

  localparam int STEP_BIT_A   = 0;
  localparam int STEP_BIT_B   = 1;
  localparam int STEP_BIT_CLK = 2;

  // strobes from control to the tap and checker datapaths
  typedef struct packed {
    logic tapRst;
    logic incClk;
    logic incA;
    logic incB;
    logic loadClk;
    logic seed;
    logic check;
    logic record;
    logic clearMap;
  } trnStb_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETTLE, ST_SEED, ST_CHECK, ST_RECORD, ST_EVAL, ST_FINISH
  } trnState_e;
endpackage

// File: rtl/adc_trn_ctrl.sv
module adc_trn_ctrl
  import adc_trn_pkg::*;
#(
  parameter int TAP_W      = 5,
  parameter int CHECK_LEN  = 256,
  parameter int SETTLE_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [REG_DW-1:0] regWrData,
  input  logic              sampleValid,
  input  logic [TAP_W-1:0]  clkTap,
  input  logic [TAP_W-1:0]  centreTap,
  input  logic              noPass,
  output trnStb_t           stb,
  output logic [TAP_W-1:0]  loadVal,
  output logic              patMode,
  output logic              busy,
  output logic              done,
  output logic              fail
);
  localparam int TAP_MAX = (1 << TAP_W) - 1;
  localparam int CNT_MAX = (CHECK_LEN > SETTLE_CYC) ? CHECK_LEN : SETTLE_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  trnState_e        state;
  logic [CNT_W-1:0] cnt;
  logic [TAP_W-1:0] startTap;

  logic idle, wrCmd, wrStep, isReset, isTrain, lastSample, settled, atTop;
  assign idle       = (state == ST_IDLE);
  assign wrCmd      = idle && regWrEn && (regAddr == ADR_CMD);
  assign wrStep     = idle && regWrEn && (regAddr == ADR_STEP);
  assign isReset    = wrCmd && (regWrData == CMD_TAP_RESET);
  assign isTrain    = wrCmd && (regWrData == CMD_TRAIN);
  assign lastSample = (cnt == CNT_W'(CHECK_LEN - 1));
  assign settled    = (cnt == CNT_W'(SETTLE_CYC - 1));
  assign atTop      = (clkTap == TAP_W'(TAP_MAX));
  assign busy       = !idle;

  always_comb begin
    stb     = '0;
    loadVal = startTap;
    unique case (state)
      ST_IDLE: begin
        stb.tapRst   = isReset;
        stb.incClk   = wrStep && regWrData[STEP_BIT_CLK];
        stb.incA     = wrStep && regWrData[STEP_BIT_A];
        stb.incB     = wrStep && regWrData[STEP_BIT_B];
        stb.loadClk  = isTrain;
        stb.clearMap = isTrain;
      end
      ST_SEED:   stb.seed  = sampleValid;
      ST_CHECK:  stb.check = sampleValid;
      ST_RECORD: begin
        stb.record = 1'b1;
        stb.incClk = !atTop;
      end
      ST_EVAL: begin
        stb.loadClk = 1'b1;
        loadVal     = noPass ? startTap : centreTap;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      startTap <= '0;
      patMode  <= 1'b0;
      done     <= 1'b0;
      fail     <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (regWrEn && regAddr == ADR_START) startTap <= regWrData[TAP_W-1:0];
          if (regWrEn && regAddr == ADR_PAT)   patMode  <= regWrData[0];
          if (isReset || isTrain) begin
            done <= 1'b0;
            fail <= 1'b0;
          end
          if (isTrain) begin
            state <= ST_SETTLE;
            cnt   <= '0;
          end
        end
        ST_SETTLE: begin
          if (settled) begin
            state <= ST_SEED;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_SEED: if (sampleValid) begin
          state <= ST_CHECK;
          cnt   <= '0;
        end
        ST_CHECK: if (sampleValid) begin
          if (lastSample) state <= ST_RECORD;
          else            cnt   <= cnt + 1'b1;
        end
        ST_RECORD: begin
          state <= atTop ? ST_EVAL : ST_SETTLE;
          cnt   <= '0;
        end
        ST_EVAL: state <= ST_FINISH;
        ST_FINISH: begin
          done  <= 1'b1;
          fail  <= noPass;
          state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: a block of checked samples only ends in the record state
  a_r7_block_ends_in_record: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CHECK && sampleValid && lastSample) |=> (state == ST_RECORD));
  // R10: done only rises out of the finish state
  a_r10_done_from_finish: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> ($past(state) == ST_FINISH));
endmodule

// File: rtl/adc_trn_taps.sv
module adc_trn_taps
  import adc_trn_pkg::*;
#(
  parameter int TAP_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  trnStb_t          stb,
  input  logic [TAP_W-1:0] loadVal,
  output logic [TAP_W-1:0] clkTap,
  output logic [TAP_W-1:0] tapA,
  output logic [TAP_W-1:0] tapB,
  output logic             clkStb,
  output logic             stbA,
  output logic             stbB
);
  localparam int NUM_DATA = 2;
  localparam logic [TAP_W-1:0] TAP_TOP = TAP_W'((1 << TAP_W) - 1);

  logic unusedStb;
  assign unusedStb = ^{stb.seed, stb.check, stb.record, stb.clearMap};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkTap <= '0;
      clkStb <= 1'b0;
    end else begin
      clkStb <= 1'b0;
      if (stb.tapRst) begin
        clkTap <= '0;
      end else if (stb.loadClk) begin
        clkTap <= loadVal;
      end else if (stb.incClk && clkTap != TAP_TOP) begin
        clkTap <= clkTap + 1'b1;
        clkStb <= 1'b1;
      end
    end
  end

  logic [TAP_W-1:0]    dTap [NUM_DATA];
  logic [NUM_DATA-1:0] dStb;
  logic [NUM_DATA-1:0] dInc;
  assign dInc = {stb.incB, stb.incA};

  for (genvar p = 0; p < NUM_DATA; p++) begin : g_data
    always_ff @(posedge clk) begin
      if (!rstN) begin
        dTap[p] <= '0;
        dStb[p] <= 1'b0;
      end else begin
        dStb[p] <= 1'b0;
        if (stb.tapRst) begin
          dTap[p] <= '0;
        end else if (dInc[p] && dTap[p] != TAP_TOP) begin
          dTap[p] <= dTap[p] + 1'b1;
          dStb[p] <= 1'b1;
        end
      end
    end

    // R4: a data tap at the top stays there unless the reset code is applied
    a_r4_data_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
      (dTap[p] == TAP_TOP && !stb.tapRst) |=> (dTap[p] == TAP_TOP));
    // R3: a data step strobe always marks a +1 move
    a_r3_data_step_one: assert property (@(posedge clk) disable iff (!rstN)
      dStb[p] |-> (dTap[p] == TAP_W'($past(dTap[p]) + 1'b1)));
  end

  assign tapA = dTap[0];
  assign tapB = dTap[1];
  assign stbA = dStb[0];
  assign stbB = dStb[1];

  // R4: the clock tap never wraps past the top
  a_r4_clk_no_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (clkTap == TAP_TOP && !stb.tapRst && !stb.loadClk) |=> (clkTap == TAP_TOP));
  // R3: a clock step strobe always marks a +1 move
  a_r3_clk_step_one: assert property (@(posedge clk) disable iff (!rstN)
    clkStb |-> (clkTap == TAP_W'($past(clkTap) + 1'b1)));
endmodule

// File: rtl/adc_trn_checker.sv
module adc_trn_checker
  import adc_trn_pkg::*;
#(
  parameter int TAP_W = 5,
  parameter int SMP_W = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  trnStb_t          stb,
  input  logic             patMode,
  input  logic [SMP_W-1:0] patConst,
  input  logic [SMP_W-1:0] sampleIn,
  input  logic [TAP_W-1:0] tapIdx,
  output logic [TAP_W-1:0] centreTap,
  output logic             noPass
);
  localparam int NUM_TAPS = 1 << TAP_W;
  localparam int LEN_W    = TAP_W + 1;

  logic unusedStb;
  assign unusedStb = ^{stb.tapRst, stb.incClk, stb.incA, stb.incB, stb.loadClk};

  logic [NUM_TAPS-1:0] passMap;
  logic [SMP_W-1:0]    prevSmp;
  logic                errSeen;
  logic [SMP_W-1:0]    expSmp;

  assign expSmp = patMode ? patConst : prevSmp + SMP_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevSmp <= '0;
      errSeen <= 1'b0;
      passMap <= '0;
    end else begin
      if (stb.seed) begin
        prevSmp <= sampleIn;
        errSeen <= 1'b0;
      end else if (stb.check) begin
        prevSmp <= sampleIn;
        errSeen <= errSeen | (sampleIn != expSmp);
      end
      if (stb.clearMap)    passMap         <= '0;
      else if (stb.record) passMap[tapIdx] <= !errSeen;
    end
  end

  // longest run of passing taps; strict compare keeps the lowest run on a tie
  logic [LEN_W-1:0] curLen, bestLen, halfLen;
  logic [TAP_W-1:0] curStart, bestStart;
  always_comb begin
    curLen    = '0;
    bestLen   = '0;
    curStart  = '0;
    bestStart = '0;
    for (int i = 0; i < NUM_TAPS; i++) begin
      if (passMap[i]) begin
        if (curLen == '0) curStart = TAP_W'(i);
        curLen = curLen + 1'b1;
        if (curLen > bestLen) begin
          bestLen   = curLen;
          bestStart = curStart;
        end
      end else begin
        curLen = '0;
      end
    end
    halfLen = (bestLen - 1'b1) >> 1;
  end

  assign centreTap = bestStart + halfLen[TAP_W-1:0];
  assign noPass    = (passMap == '0);

  // R7: a tap that saw an error is recorded as failing
  a_r7_error_fails_tap: assert property (@(posedge clk) disable iff (!rstN)
    (stb.record && errSeen && !stb.clearMap) |=> !passMap[$past(tapIdx)]);
endmodule

// File: rtl/adc_eye_trainer.sv
module adc_eye_trainer
  import adc_trn_pkg::*;
#(
  parameter int TAP_W      = 5,
  parameter int SMP_W      = 14,
  parameter int CHECK_LEN  = 256,
  parameter int SETTLE_CYC = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [REG_DW-1:0] regWrData,
  input  logic              sampleValid,
  input  logic [SMP_W-1:0]  sampleIn,
  input  logic [SMP_W-1:0]  patConst,
  output logic [TAP_W-1:0]  clkTap,
  output logic [TAP_W-1:0]  dataTapA,
  output logic [TAP_W-1:0]  dataTapB,
  output logic              clkStepStb,
  output logic              dataStepStbA,
  output logic              dataStepStbB,
  output logic              trainBusy,
  output logic              trainDone,
  output logic              trainFail
);
  trnStb_t          stb;
  logic [TAP_W-1:0] loadVal, centreTap;
  logic             noPass, patMode;

  adc_trn_ctrl #(.TAP_W(TAP_W), .CHECK_LEN(CHECK_LEN), .SETTLE_CYC(SETTLE_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .sampleValid(sampleValid), .clkTap(clkTap), .centreTap(centreTap), .noPass(noPass),
    .stb(stb), .loadVal(loadVal), .patMode(patMode),
    .busy(trainBusy), .done(trainDone), .fail(trainFail)
  );

  adc_trn_taps #(.TAP_W(TAP_W)) u_taps (
    .clk(clk), .rstN(rstN), .stb(stb), .loadVal(loadVal),
    .clkTap(clkTap), .tapA(dataTapA), .tapB(dataTapB),
    .clkStb(clkStepStb), .stbA(dataStepStbA), .stbB(dataStepStbB)
  );

  adc_trn_checker #(.TAP_W(TAP_W), .SMP_W(SMP_W)) u_chk (
    .clk(clk), .rstN(rstN), .stb(stb), .patMode(patMode), .patConst(patConst),
    .sampleIn(sampleIn), .tapIdx(clkTap), .centreTap(centreTap), .noPass(noPass)
  );

  // R5: data taps hold still during training
  a_r5_busy_holds_data: assert property (@(posedge clk) disable iff (!rstN)
    trainBusy |=> ($stable(dataTapA) && $stable(dataTapB)));
  // R10: done and busy are never high together
  a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rstN)
    trainDone |-> !trainBusy);
  // R9: fail is only reported with done
  a_r9_fail_with_done: assert property (@(posedge clk) disable iff (!rstN)
    trainFail |-> trainDone);
  // R2: the reset code while idle zeroes all taps and clears done
  a_r2_reset_code: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == ADR_CMD && regWrData == CMD_TAP_RESET && !trainBusy)
    |=> (clkTap == '0 && dataTapA == '0 && dataTapB == '0 && !trainDone));
endmodule

// File: tb/tb_adc_eye_trainer.sv
module tb_adc_eye_trainer;
  localparam int SMP_W = 14;
  localparam int WD_CYCLES = 190000;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             regWrEn = 1'b0;
  logic [1:0]       regAddr = '0;
  logic [7:0]       regWrData = '0;
  logic             sampleValid = 1'b0;
  logic [SMP_W-1:0] sampleIn = '0;
  logic [SMP_W-1:0] patConst = 14'h2A5C;
  logic [4:0]       clkTap, dataTapA, dataTapB;
  logic             clkStepStb, dataStepStbA, dataStepStbB;
  logic             trainBusy, trainDone, trainFail;

  adc_eye_trainer dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .sampleValid(sampleValid), .sampleIn(sampleIn), .patConst(patConst),
    .clkTap(clkTap), .dataTapA(dataTapA), .dataTapB(dataTapB),
    .clkStepStb(clkStepStb), .dataStepStbA(dataStepStbA), .dataStepStbB(dataStepStbB),
    .trainBusy(trainBusy), .trainDone(trainDone), .trainFail(trainFail)
  );

  always #10 clk = ~clk;

  int  checks = 0;
  int  failures = 0;
  bit  finished = 0;
  logic [31:0]      goodMask = '0;
  bit               tbPatMode = 0;
  logic [SMP_W-1:0] rampVal = '0;
  int               smpCnt = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // delay element and ADC model: bad clock taps corrupt every 50th valid sample
  initial begin
    forever begin
      @(negedge clk);
      sampleValid = ($urandom % 4) != 0;
      if (sampleValid) begin
        logic [SMP_W-1:0] s;
        s = tbPatMode ? patConst : rampVal;
        rampVal = rampVal + 1'b1;
        smpCnt++;
        if (!goodMask[clkTap] && (smpCnt % 50 == 0)) s[smpCnt % SMP_W] = ~s[smpCnt % SMP_W];
        sampleIn = s;
      end else begin
        sampleIn = SMP_W'($urandom);
      end
    end
  end

  function automatic int expCentre(input logic [31:0] m, input int s, output bit none);
    int cur, bestLen, bestStart;
    cur = 0; bestLen = 0; bestStart = 0;
    for (int i = s; i < 32; i++) begin
      if (m[i]) begin
        cur++;
        if (cur > bestLen) begin bestLen = cur; bestStart = i - cur + 1; end
      end else cur = 0;
    end
    none = (bestLen == 0);
    return none ? s : bestStart + (bestLen - 1) / 2;
  endfunction

  task automatic runTrain(input logic [31:0] m, input int s, input bit mode, input bit meddle);
    int exp, maxTap, prevTap, cyc, holdA, holdB;
    bit none;
    exp = expCentre(m, s, none);
    goodMask = m;
    tbPatMode = mode;
    regWrite(2'd3, {7'd0, mode});
    regWrite(2'd1, 8'(s));
    regWrite(2'd0, 8'h40);
    chk(trainBusy == 1'b1, "R6 busy after start", trainBusy, 1);
    chk(trainDone == 1'b0, "R10 done cleared by start", trainDone, 0);
    chk(int'(clkTap) == s, "R6 clock tap loaded with start", clkTap, s);
    holdA = dataTapA; holdB = dataTapB;
    maxTap = clkTap; prevTap = clkTap; cyc = 0;
    if (meddle) begin
      repeat (100) @(negedge clk);
      regWrite(2'd2, 8'h07);
      regWrite(2'd0, 8'h13);
      chk(int'(dataTapA) == holdA, "R5 step ignored while busy (A)", dataTapA, holdA);
      chk(int'(dataTapB) == holdB, "R5 reset ignored while busy (B)", dataTapB, holdB);
      chk(trainBusy == 1'b1, "R5 training continues", trainBusy, 1);
    end
    while (!trainDone && cyc < 60000) begin
      prevTap = clkTap;
      @(negedge clk);
      cyc++;
      if (trainBusy && int'(clkTap) > maxTap) maxTap = clkTap;
    end
    chk(maxTap == 31, "R7 sweep reaches top tap", maxTap, 31);
    chk(prevTap == exp, "R10 final tap applied one cycle before done", prevTap, exp);
    chk(int'(clkTap) == exp, none ? "R9 tap back at start" : "R8 centre of longest run", clkTap, exp);
    chk(trainFail == none, "R9 fail flag", trainFail, none);
    chk(trainBusy == 1'b0, "R10 busy low with done", trainBusy, 0);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL R10 watchdog expired actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(clkTap == 0 && dataTapA == 0 && dataTapB == 0, "R1 taps zero after reset",
        clkTap + dataTapA + dataTapB, 0);
    chk(!clkStepStb && !dataStepStbA && !dataStepStbB, "R1 no strobe after reset",
        clkStepStb + dataStepStbA + dataStepStbB, 0);
    chk(!trainBusy && !trainDone && !trainFail, "R1 status low after reset",
        trainBusy + trainDone + trainFail, 0);

    // R3 manual steps
    regWrite(2'd2, 8'h04);
    chk(clkTap == 1 && clkStepStb, "R3 clock step via bit 2", clkTap, 1);
    chk(dataTapA == 0 && !dataStepStbA, "R3 bit 2 leaves port A", dataTapA, 0);
    regWrite(2'd2, 8'h01);
    chk(dataTapA == 1 && dataStepStbA && !clkStepStb, "R3 port A step via bit 0", dataTapA, 1);
    regWrite(2'd2, 8'h02);
    chk(dataTapB == 1 && dataStepStbB, "R3 port B step via bit 1", dataTapB, 1);
    regWrite(2'd2, 8'h07);
    chk(clkTap == 2 && dataTapA == 2 && dataTapB == 2, "R3 all three step together",
        clkTap + dataTapA + dataTapB, 6);
    @(negedge clk);
    chk(!clkStepStb && !dataStepStbA && !dataStepStbB, "R3 strobes last one cycle",
        clkStepStb + dataStepStbA + dataStepStbB, 0);

    // R2 command register
    regWrite(2'd0, 8'h12);
    chk(clkTap == 2 && dataTapA == 2 && dataTapB == 2, "R2 other command value ignored",
        clkTap + dataTapA + dataTapB, 6);
    regWrite(2'd0, 8'h13);
    chk(clkTap == 0 && dataTapA == 0 && dataTapB == 0, "R2 reset code zeroes taps",
        clkTap + dataTapA + dataTapB, 0);

    // R4 saturation
    repeat (35) regWrite(2'd2, 8'h07);
    chk(clkTap == 31 && dataTapA == 31 && dataTapB == 31, "R4 taps saturate at 31",
        clkTap + dataTapA + dataTapB, 93);
    regWrite(2'd2, 8'h07);
    chk(!clkStepStb && !dataStepStbA && !dataStepStbB, "R4 no strobe at top",
        clkStepStb + dataStepStbA + dataStepStbB, 0);
    chk(clkTap == 31, "R4 clock tap stays 31", clkTap, 31);

    regWrite(2'd0, 8'h13);
    repeat (3) regWrite(2'd2, 8'h01);
    chk(dataTapA == 3, "R3 port A at 3 before training", dataTapA, 3);

    // R7 R8 ramp sweep from 0 with writes during busy (R5)
    runTrain(32'h001F_FC00, 0, 1'b0, 1'b1);
    repeat (10) @(negedge clk);
    chk(trainDone == 1'b1, "R10 done holds", trainDone, 1);
    regWrite(2'd0, 8'h13);
    chk(trainDone == 1'b0 && clkTap == 0, "R2 reset code clears done", trainDone, 0);

    // R8 longer upper run in constant mode
    runTrain(32'h0FF0_01E0, 2, 1'b1, 1'b0);
    // R8 run clipped by the start tap
    runTrain(32'h0FF0_0000, 24, 1'b1, 1'b0);
    // R9 nothing passes
    runTrain(32'h0000_0000, 7, 1'b0, 1'b0);
    // R8 tie keeps the lower run
    runTrain(32'h0000_0E38, 0, 1'b0, 1'b0);
    // random eyes
    for (int k = 0; k < 2; k++) runTrain($urandom, 16, 1'(k), 1'b0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule